// File: doc/BRIEF.md
# Pipelined ARX Block Encryption Round Datapath

This block encrypts one 128-bit block, held as four 32-bit words, with an iterated add-rotate-xor round. It applies the round 28 times and uses a fresh 192-bit round key, as six 32-bit words, for each pass. A pass builds three new words. Each comes from a sum, modulo 2^32, of two key-masked words, followed by a fixed rotation. The fourth new word is a plain copy of the old first word.

Round keys come from an external key source. The block raises a request and gives the round index. The source must present the matching key on the same cycle, so a small table or an on-the-fly expander can sit beside it. The key is registered in a short pipeline before it reaches the adders. This keeps the round logic between flops. The finished state passes through output stages. The overall latency from acceptance to the result pulse is fixed at 33 cycles with the default parameters.

Only one block is in flight at a time. The block accepts a plaintext while it is idle, holds busy until the result pulse, and then keeps the ciphertext on its output until the next block completes.

Top module: `arx_block_encrypt`

## Requirements
- R1: A synchronous reset, active high, drives busy, ct_valid and rk_req low on the following clock edge and abandons any block in flight, with no result pulse for it.
- R2: Word j of pt_data, ct_data and rk_data sits at bits [32j+31:32j]. With the result pulse, ct_data equals the state after 28 rounds applied to the accepted plaintext, round r using the key delivered for index r.
- R3: In every round, new word 0 = rotate-left by 9 of ((word0 XOR key0) + (word1 XOR key1)).
- R4: In every round, new word 1 = rotate-right by 5 of ((word1 XOR key2) + (word2 XOR key3)).
- R5: In every round, new word 2 = rotate-right by 3 of ((word2 XOR key4) + (word3 XOR key5)).
- R6: In every round, new word 3 equals the old word 0.
- R7: After an acceptance edge, rk_req is high for exactly 28 consecutive cycles. rk_idx counts 0 up to 27 in those cycles, and the key is sampled in the same cycle as its index.
- R8: ct_valid is a single-cycle pulse. It is high in the cycle after the 33rd rising edge that follows the edge that accepted the plaintext.
- R9: A plaintext is accepted on an edge where pt_valid is high and busy is low. Busy is high from the cycle after acceptance until the cycle before the result pulse, and it is low in the pulse cycle. pt_valid while busy is high is ignored.
- R10: ct_data keeps its value in every cycle without a result pulse, across resets as well.
- R11: Sums drop the carry out of bit 31. For example, all-ones plaintext with zero keys gives a first-round word 0 of 0xFFFFFDFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| pt_valid | input | 1 | Plaintext offered this cycle |
| pt_data | input | 128 | Plaintext, word j at bits 32j+31:32j |
| busy | output | 1 | A block is in flight; new plaintext is ignored |
| rk_req | output | 1 | Round key requested this cycle |
| rk_idx | output | 5 | Index of the requested round key |
| rk_data | input | 192 | Key for rk_idx, word j at bits 32j+31:32j |
| ct_valid | output | 1 | One-cycle result pulse |
| ct_data | output | 128 | Ciphertext, held until the next result |

## Verification
A behavioural model in the bench predicts busy, the key requests and the result pulse on every clock. The stimulus includes a pseudo-random plaintext and key set, an all-zero block with all-zero keys, and an all-ones block with zero keys. The first shows the full round mix. The second shows that a stuck key path or word order goes unnoticed only when everything is zero. The third drives carries out of bit 31 in every sum. A second instance built for one round checks each word formula and rotation on its own. A continuous stream of changing pt_valid data shows that words offered while busy leave the result untouched and that acceptance resumes in the pulse cycle. A reset in mid-block shows that the pending result is dropped while the old ciphertext stays on the output.

// File: rtl/arx_enc_pkg.sv
package arx_enc_pkg;

   // number of word lanes that perform add-rotate-xor in each round
   localparam int ARX_LANES = 3;

   // left-rotation amount of a lane; right rotations are expressed as W - n
   function automatic int lane_rol(input int lane, input int w);
      case (lane)
         0:       return 9;
         1:       return w - 5;
         default: return w - 3;
      endcase
   endfunction

endpackage

// File: rtl/arx_dly.sv
module arx_dly #(
   parameter int W     = 8,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (DEPTH < 0) begin : g_bad_depth
      $error("arx_dly: DEPTH must not be negative");
   end

   generate
      if (DEPTH == 0) begin : g_wire
         assign q = d;
      end else begin : g_regs
         logic [W-1:0] stg [DEPTH];
         always_ff @(posedge clk) begin
            stg[0] <= d;
            for (int i = 1; i < DEPTH; i++) begin
               stg[i] <= stg[i-1];
            end
         end
         assign q = stg[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/arx_lane.sv
module arx_lane #(
   parameter int W   = 32,
   parameter int ROL = 9
) (
   input  logic [W-1:0] xa,
   input  logic [W-1:0] xb,
   input  logic [W-1:0] ka,
   input  logic [W-1:0] kb,
   output logic [W-1:0] y
);

   if (ROL < 1 || ROL >= W) begin : g_bad_rol
      $error("arx_lane: ROL must lie in 1..W-1");
   end

   logic [W-1:0] sum;

   always_comb begin
      sum = (xa ^ ka) + (xb ^ kb);
      y   = (sum << ROL) | (sum >> (W - ROL));
   end

endmodule

// File: rtl/arx_round.sv
module arx_round #(
   parameter int W = 32
) (
   input  logic [4*W-1:0] x,
   input  logic [6*W-1:0] k,
   output logic [4*W-1:0] y
);
   import arx_enc_pkg::*;

   genvar i;
   generate
      for (i = 0; i < ARX_LANES; i++) begin : g_lane
         arx_lane #(
            .W   (W),
            .ROL (lane_rol(i, W))
         ) u_lane (
            .xa (x[i*W     +: W]),
            .xb (x[(i+1)*W +: W]),
            .ka (k[2*i*W   +: W]),
            .kb (k[(2*i+1)*W +: W]),
            .y  (y[i*W     +: W])
         );
      end
   endgenerate

   // last word takes the old first word unchanged
   assign y[3*W +: W] = x[0 +: W];

endmodule

// File: rtl/arx_ctrl.sv
module arx_ctrl #(
   parameter int ROUNDS   = 28,
   parameter int KEY_PIPE = 2,
   parameter int OUT_PIPE = 3,
   parameter int IDXW     = 5
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            pt_valid,
   output logic            accept,
   output logic            busy,
   output logic            step,
   output logic            load_ct,
   output logic            done,
   output logic            rk_req,
   output logic [IDXW-1:0] rk_idx
);

   localparam int LAT  = ROUNDS + KEY_PIPE + OUT_PIPE;
   localparam int CNTW = $clog2(LAT + 1);
   localparam logic [CNTW-1:0] C_ROUNDS = CNTW'(ROUNDS);
   localparam logic [CNTW-1:0] C_KP     = CNTW'(KEY_PIPE);
   localparam logic [CNTW-1:0] C_STEPND = CNTW'(KEY_PIPE + ROUNDS);
   localparam logic [CNTW-1:0] C_LAST   = CNTW'(LAT - 1);

   if (CNTW < IDXW) begin : g_bad_idxw
      $error("arx_ctrl: counter narrower than the key index");
   end

   logic [CNTW-1:0] cnt;

   assign accept  = pt_valid & ~busy;
   assign rk_req  = busy && (cnt < C_ROUNDS);
   assign rk_idx  = rk_req ? cnt[IDXW-1:0] : '0;
   assign step    = busy && (cnt >= C_KP) && (cnt < C_STEPND);
   assign load_ct = busy && (cnt == C_LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy <= 1'b0;
         done <= 1'b0;
         cnt  <= '0;
      end else begin
         done <= 1'b0;
         if (busy) begin
            if (cnt == C_LAST) begin
               busy <= 1'b0;
               done <= 1'b1;
               cnt  <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else if (pt_valid) begin
            busy <= 1'b1;
            cnt  <= '0;
         end
      end
   end

   // R8
   valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R9
   busy_gap_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);

   // R9
   accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
      (pt_valid && !busy) |=> busy);

   // R7
   idx_step_chk: assert property (@(posedge clk) disable iff (rst)
      (rk_req && $past(rk_req)) |-> (rk_idx == $past(rk_idx) + 1'b1));

   // R7
   req_first_chk: assert property (@(posedge clk) disable iff (rst)
      (pt_valid && !busy) |=> (rk_req && rk_idx == '0));

endmodule

// File: rtl/arx_block_encrypt.sv
module arx_block_encrypt #(
   parameter int WORD_W   = 32,
   parameter int ROUNDS   = 28,
   parameter int KEY_PIPE = 2,
   parameter int OUT_PIPE = 3,
   parameter int IDXW     = (ROUNDS > 1) ? $clog2(ROUNDS) : 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                pt_valid,
   input  logic [4*WORD_W-1:0] pt_data,
   output logic                busy,
   output logic                rk_req,
   output logic [IDXW-1:0]     rk_idx,
   input  logic [6*WORD_W-1:0] rk_data,
   output logic                ct_valid,
   output logic [4*WORD_W-1:0] ct_data
);

   localparam int BLK_W = 4 * WORD_W;
   localparam int KEY_W = 6 * WORD_W;

   if (ROUNDS < 1) begin : g_bad_rounds
      $error("arx_block_encrypt: ROUNDS must be at least 1");
   end
   if (KEY_PIPE < 1) begin : g_bad_kp
      $error("arx_block_encrypt: KEY_PIPE must be at least 1");
   end
   if (OUT_PIPE < 1) begin : g_bad_op
      $error("arx_block_encrypt: OUT_PIPE must be at least 1");
   end
   if (WORD_W <= 9) begin : g_bad_w
      $error("arx_block_encrypt: WORD_W must exceed the largest rotation");
   end

   logic             accept, step, load_ct;
   logic [BLK_W-1:0] x_q, x_nxt, x_late, ct_q;
   logic [KEY_W-1:0] rk_q;

   arx_ctrl #(
      .ROUNDS   (ROUNDS),
      .KEY_PIPE (KEY_PIPE),
      .OUT_PIPE (OUT_PIPE),
      .IDXW     (IDXW)
   ) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .pt_valid (pt_valid),
      .accept   (accept),
      .busy     (busy),
      .step     (step),
      .load_ct  (load_ct),
      .done     (ct_valid),
      .rk_req   (rk_req),
      .rk_idx   (rk_idx)
   );

   // key registers between the key source and the adders
   arx_dly #(.W(KEY_W), .DEPTH(KEY_PIPE)) u_key_pipe (
      .clk (clk),
      .d   (rk_data),
      .q   (rk_q)
   );

   arx_round #(.W(WORD_W)) u_round (
      .x (x_q),
      .k (rk_q),
      .y (x_nxt)
   );

   always_ff @(posedge clk) begin
      if (accept) begin
         x_q <= pt_data;
      end else if (step) begin
         x_q <= x_nxt;
      end
   end

   // output stages; the last one is the held ciphertext register
   arx_dly #(.W(BLK_W), .DEPTH(OUT_PIPE - 1)) u_out_pipe (
      .clk (clk),
      .d   (x_q),
      .q   (x_late)
   );

   always_ff @(posedge clk) begin
      if (load_ct) begin
         ct_q <= x_late;
      end
   end

   assign ct_data = ct_q;

   // R10
   ct_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !ct_valid |-> $stable(ct_data));

   // R8
   done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
      ct_valid |-> $past(busy));

   // R9
   no_step_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !busy |-> !rk_req);

endmodule

// File: tb/arx_block_encrypt_bench.sv
`timescale 1ns/1ps
module arx_block_encrypt_bench;

   localparam int NR   = 28;
   localparam int LAT  = 33;
   localparam int LAT1 = 6;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         pt_valid = 1'b0;
   logic [127:0] pt_data = '0;
   logic         busy, rk_req, ct_valid;
   logic [4:0]   rk_idx;
   logic [191:0] rk_data;
   logic [127:0] ct_data;

   logic         busy1, rk_req1, ct_valid1;
   logic [0:0]   rk_idx1;
   logic [191:0] rk_data1;
   logic [127:0] ct_data1;

   logic [191:0] rk_tab [NR];

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   assign rk_data  = (rk_idx < 5'(NR)) ? rk_tab[rk_idx] : '0;
   assign rk_data1 = rk_tab[0];

   arx_block_encrypt u_arx_block_encrypt (
      .clk (clk), .rst (rst), .pt_valid (pt_valid), .pt_data (pt_data),
      .busy (busy), .rk_req (rk_req), .rk_idx (rk_idx), .rk_data (rk_data),
      .ct_valid (ct_valid), .ct_data (ct_data)
   );

   arx_block_encrypt #(.ROUNDS(1)) u_arx_block_encrypt_one (
      .clk (clk), .rst (rst), .pt_valid (pt_valid), .pt_data (pt_data),
      .busy (busy1), .rk_req (rk_req1), .rk_idx (rk_idx1), .rk_data (rk_data1),
      .ct_valid (ct_valid1), .ct_data (ct_data1)
   );

   function automatic logic [31:0] rol(input logic [31:0] v, input int n);
      return (v << n) | (v >> (32 - n));
   endfunction

   function automatic logic [127:0] one_round(input logic [127:0] x, input logic [191:0] k);
      logic [31:0] w [4];
      logic [31:0] kk [6];
      logic [31:0] s;
      logic [127:0] r;
      for (int i = 0; i < 4; i++) w[i] = x[32*i +: 32];
      for (int j = 0; j < 6; j++) kk[j] = k[32*j +: 32];
      s = (w[0] ^ kk[0]) + (w[1] ^ kk[1]); r[31:0]   = rol(s, 9);
      s = (w[1] ^ kk[2]) + (w[2] ^ kk[3]); r[63:32]  = rol(s, 27);
      s = (w[2] ^ kk[4]) + (w[3] ^ kk[5]); r[95:64]  = rol(s, 29);
      r[127:96] = w[0];
      return r;
   endfunction

   function automatic logic [127:0] encrypt(input logic [127:0] p);
      logic [127:0] x = p;
      for (int r = 0; r < NR; r++) x = one_round(x, rk_tab[r]);
      return x;
   endfunction

   // behavioural model state
   bit           m_busy = 0, m_valid = 0, m_have = 0, m_rstd = 1;
   int           m_cnt = 0;
   logic [127:0] m_res, m_ct;
   bit           o_busy = 0, o_valid = 0;
   int           o_cnt = 0;
   logic [127:0] o_res, o_pt, o_ptres;
   logic [191:0] o_key, o_keyres;

   task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                      input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      m_rstd = rst;
      if (rst) begin
         m_busy = 0; m_valid = 0; m_cnt = 0;
         o_busy = 0; o_valid = 0; o_cnt = 0;
      end else begin
         m_valid = 0;
         if (m_busy) begin
            m_cnt++;
            if (m_cnt == LAT) begin
               m_busy = 0; m_valid = 1; m_ct = m_res; m_have = 1;
            end
         end else if (pt_valid) begin
            m_busy = 1; m_cnt = 0; m_res = encrypt(pt_data);
         end
         o_valid = 0;
         if (o_busy) begin
            o_cnt++;
            if (o_cnt == LAT1) begin
               o_busy = 0; o_valid = 1; o_ptres = o_pt; o_keyres = o_key;
            end
         end else if (pt_valid) begin
            o_busy = 1; o_cnt = 0; o_pt = pt_data; o_key = rk_tab[0];
         end
      end
      @(negedge clk);
      if (m_rstd) begin
         chk(busy == 1'b0, "R1 busy", 128'(busy), 128'(0));
         chk(ct_valid == 1'b0, "R1 ct_valid", 128'(ct_valid), 128'(0));
         chk(rk_req == 1'b0, "R1 rk_req", 128'(rk_req), 128'(0));
      end else begin
         chk(busy == m_busy, "R9 busy", 128'(busy), 128'(m_busy));
         chk(ct_valid == m_valid, "R8 ct_valid", 128'(ct_valid), 128'(m_valid));
         chk(rk_req == (m_busy && m_cnt < NR), "R7 rk_req", 128'(rk_req),
             128'(m_busy && m_cnt < NR));
         if (m_busy && m_cnt < NR)
            chk(rk_idx == 5'(m_cnt), "R7 rk_idx", 128'(rk_idx), 128'(m_cnt));
         chk(ct_valid1 == o_valid, "R8 one-round ct_valid", 128'(ct_valid1),
             128'(o_valid));
      end
      if (m_have)
         chk(ct_data == m_ct, m_valid ? "R2 ciphertext" : "R10 held ciphertext",
             ct_data, m_ct);
      if (o_valid) begin
         o_res = one_round(o_ptres, o_keyres);
         chk(ct_data1[31:0] == o_res[31:0], "R3 word0", 128'(ct_data1[31:0]),
             128'(o_res[31:0]));
         chk(ct_data1[63:32] == o_res[63:32], "R4 word1", 128'(ct_data1[63:32]),
             128'(o_res[63:32]));
         chk(ct_data1[95:64] == o_res[95:64], "R5 word2", 128'(ct_data1[95:64]),
             128'(o_res[95:64]));
         chk(ct_data1[127:96] == o_res[127:96], "R6 word3", 128'(ct_data1[127:96]),
             128'(o_res[127:96]));
      end
   endtask

   task automatic fill_keys(input logic [31:0] seed);
      logic [31:0] s = seed;
      for (int r = 0; r < NR; r++) begin
         for (int j = 0; j < 6; j++) begin
            s = s * 32'd1664525 + 32'd1013904223;
            rk_tab[r][32*j +: 32] = s;
         end
      end
   endtask

   task automatic zero_keys();
      for (int r = 0; r < NR; r++) rk_tab[r] = '0;
   endtask

   task automatic one_block(input logic [127:0] p, input int wait_cycles);
      pt_data  = p;
      pt_valid = 1'b1;
      tick();
      pt_valid = 1'b0;
      repeat (wait_cycles) tick();
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      fill_keys(32'h0000_0001);
      repeat (3) tick();
      rst = 1'b0;
      // pseudo-random block, R2 and R8
      one_block(128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210, 40);
      // all-zero block with zero keys
      zero_keys();
      one_block('0, 40);
      // continuous offers with changing data, R9: busy words ignored
      fill_keys(32'h0000_004d);
      for (int i = 0; i < 80; i++) begin
         pt_valid = 1'b1;
         pt_data  = {32'(i * 7), 32'hdead_0000 + 32'(i), 32'(i * 13), 32'h5a5a_5a5a ^ 32'(i)};
         tick();
      end
      pt_valid = 1'b0;
      repeat (40) tick();
      // carry vector, R11
      zero_keys();
      one_block('1, 40);
      chk(ct_data1[31:0] == 32'hFFFF_FDFF, "R11 carry dropped",
          128'(ct_data1[31:0]), 128'h FFFF_FDFF);
      // reset in mid-block, R1 and R10
      fill_keys(32'h0000_0005);
      one_block(128'hcafe_f00d_1234_5678_0bad_beef_8765_4321, 10);
      rst = 1'b1;
      tick();
      rst = 1'b0;
      repeat (40) tick();
      one_block(128'h1111_2222_3333_4444_5555_6666_7777_8888, 40);
      summary();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=expired expected=completion");
      summary();
   end

endmodule